// File: doc/BRIEF.md
# Subtract-and-Branch Processor Core

This block is a minimal processor that has exactly one kind of instruction. There is no opcode field. Every instruction is four consecutive memory words. The first three are data addresses A, B and C, and the fourth is a branch target D. The core subtracts the word at A from the word at B and writes the difference to C. It jumps to D when that difference is negative and otherwise moves on to the next instruction. Even with one instruction, it can express loops, copies and conditional code.

Code and data share one internal word memory. While the core is not running, a write port fills the memory, and a read port returns any word so the results can be inspected. Reset clears the program counter. A pulse on `start` launches execution from address 0. The core stops by itself on a branch that targets the instruction it sits in, and it then raises `halt`. Each instruction takes seven cycles: four field fetches, two operand reads and one result write. The memory is touched exactly once in each of those cycles.

Data words are 16-bit two's complement by default. Address fields use their low `ADDR_W` bits.

Top module: `subbr_core`

## Requirements
- R1: In the cycle after synchronous reset is released, `pc` is 0 and both `busy` and `halt` are 0.
- R2: If `start` is sampled high while the core is idle, `busy` is 1 in the next cycle. While `start` stays low, the core stays idle with `pc` at 0.
- R3: The instruction at address p is the words at p, p+1, p+2 and p+3, read as A, B, C and D. The low `ADDR_W` bits of each word form an address. The core stores (mem[B] - mem[A]) modulo 2^DATA_W into mem[C].
- R4: When bit DATA_W-1 of the stored difference is 1, the next `pc` is D.
- R5: When the stored difference is zero or has bit DATA_W-1 at 0, the next `pc` is p+4, modulo 2^ADDR_W.
- R6: When C equals A or B, both operands are read before the write, so the difference is formed from the old values.
- R7: A taken branch whose D equals the current p sets `halt` to 1. After that, `halt` stays 1, `busy` stays 0 and `pc` holds, and `start` has no effect until reset.
- R8: Each instruction takes 7 clock cycles. A program that executes N instructions, the last being the halting one, raises `halt` on the 7N-th clock edge after the edge that sampled `start`.
- R9: A write through the loader port (`load_we` high) is applied at the clock edge only when `busy` is 0. While `busy` is 1, such a write leaves memory unchanged.
- R10: The branch decision uses the sign bit of the wrapped difference, not a true comparison. For example, 0x8000 - 0x0001 gives 0x7FFF, which does not branch, and 0x7FFF - 0xFFFF gives 0x8000, which branches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch execution from address 0 when idle |
| load_we | input | 1 | Loader write enable, honoured only while not busy |
| load_addr | input | ADDR_W | Loader write address |
| load_data | input | DATA_W | Loader write data |
| peek_addr | input | ADDR_W | Inspection read address |
| peek_data | output | DATA_W | Word at `peek_addr`, combinational |
| pc | output | ADDR_W | Address of the current instruction |
| busy | output | 1 | Core is executing |
| halt | output | 1 | Core stopped on a branch to itself |

## Verification
The bench targets the sign boundary in three ways: a zero difference that must fall through, wrapped overflows in both directions, and a negative result that must redirect `pc`. A core that compared operands directly, or treated zero as negative, would stop at the wrong address. It also has the result overwrite one of its own operands, which would corrupt the difference if the write came before the second read. It checks the cycle count of whole programs, which catches any missing or extra step. A counting loop confirms that a loader write issued mid-run is dropped and that `halt` cannot be left by a new `start`.

// File: rtl/subbr_pkg.sv
package subbr_pkg;

    // Words per instruction: A, B, C, D
    localparam int unsigned FIELDS = 4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH_A,
        S_FETCH_B,
        S_FETCH_C,
        S_FETCH_D,
        S_READ_A,
        S_READ_B,
        S_WRITE_C,
        S_HALT
    } core_state_e;

    function automatic logic is_fetch(core_state_e s);
        return s inside {S_FETCH_A, S_FETCH_B, S_FETCH_C, S_FETCH_D};
    endfunction

    // Word offset within the instruction for a fetch state
    function automatic logic [1:0] fetch_slot(core_state_e s);
        case (s)
            S_FETCH_B: return 2'd1;
            S_FETCH_C: return 2'd2;
            S_FETCH_D: return 2'd3;
            default:   return 2'd0;
        endcase
    endfunction

    function automatic logic is_active(core_state_e s);
        return !(s == S_IDLE || s == S_HALT);
    endfunction

    function automatic core_state_e step_after(core_state_e s, logic go, logic stop);
        case (s)
            S_IDLE:    return go ? S_FETCH_A : S_IDLE;
            S_FETCH_A: return S_FETCH_B;
            S_FETCH_B: return S_FETCH_C;
            S_FETCH_C: return S_FETCH_D;
            S_FETCH_D: return S_READ_A;
            S_READ_A:  return S_READ_B;
            S_READ_B:  return S_WRITE_C;
            S_WRITE_C: return stop ? S_HALT : S_FETCH_A;
            default:   return S_HALT;
        endcase
    endfunction

endpackage

// File: rtl/subbr_mem.sv
module subbr_mem #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign rdata     = cells[addr];
    assign peek_data = cells[peek_addr];
endmodule

// File: rtl/subbr_ctrl.sv
module subbr_ctrl
    import subbr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        stop,
    output core_state_e state
);
    core_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= step_after(state_q, start, stop);
    end

    assign state = state_q;
endmodule

// File: rtl/subbr_alu.sv
module subbr_alu
    import subbr_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 8
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [ADDR_W-1:0] target,
    output logic [DATA_W-1:0] diff,
    output logic [ADDR_W-1:0] next_pc,
    output logic              stop
);
    logic negative;

    always_comb begin
        diff     = opnd_b - opnd_a;
        negative = diff[DATA_W-1];
        next_pc  = negative ? target : cur_pc + ADDR_W'(FIELDS);
        stop     = negative && (target == cur_pc);
    end
endmodule

// File: rtl/subbr_dpath.sv
module subbr_dpath
    import subbr_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  core_state_e       state,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [ADDR_W-1:0] next_pc,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] cur_pc
);
    logic [ADDR_W-1:0] fld_q [FIELDS];
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] opa_q;
    logic [DATA_W-1:0] opb_q;

    for (genvar i = 0; i < FIELDS; i++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst)
                fld_q[i] <= '0;
            else if (is_fetch(state) && fetch_slot(state) == 2'(i))
                fld_q[i] <= mem_rdata[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            opa_q <= '0;
            opb_q <= '0;
        end else begin
            if (state == S_READ_A)  opa_q <= mem_rdata;
            if (state == S_READ_B)  opb_q <= mem_rdata;
            if (state == S_WRITE_C) pc_q  <= next_pc;
        end
    end

    always_comb begin
        case (state)
            S_FETCH_A, S_FETCH_B, S_FETCH_C, S_FETCH_D:
                mem_addr = pc_q + ADDR_W'(fetch_slot(state));
            S_READ_A:  mem_addr = fld_q[0];
            S_READ_B:  mem_addr = fld_q[1];
            S_WRITE_C: mem_addr = fld_q[2];
            default:   mem_addr = pc_q;
        endcase
        mem_we = (state == S_WRITE_C);
    end

    assign opnd_a = opa_q;
    assign opnd_b = opb_q;
    assign target = fld_q[3];
    assign cur_pc = pc_q;
endmodule

// File: rtl/subbr_core.sv
module subbr_core
    import subbr_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              load_we,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data,
    output logic [ADDR_W-1:0] pc,
    output logic              busy,
    output logic              halt
);
    core_state_e       state;
    logic              stop;
    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] diff;
    logic [ADDR_W-1:0] next_pc;
    logic [ADDR_W-1:0] core_addr;
    logic              core_we;
    logic [DATA_W-1:0] opnd_a;
    logic [DATA_W-1:0] opnd_b;
    logic [ADDR_W-1:0] jump_tgt;
    logic [ADDR_W-1:0] cur_pc;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;

    subbr_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .stop  (stop),
        .state (state)
    );

    subbr_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .mem_rdata (mem_rdata),
        .next_pc   (next_pc),
        .mem_addr  (core_addr),
        .mem_we    (core_we),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .target    (jump_tgt),
        .cur_pc    (cur_pc)
    );

    subbr_alu #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_alu (
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .cur_pc  (cur_pc),
        .target  (jump_tgt),
        .diff    (diff),
        .next_pc (next_pc),
        .stop    (stop)
    );

    // The running core owns the memory port; the loader gets it otherwise
    always_comb begin
        busy = is_active(state);
        if (busy) begin
            mem_we    = core_we;
            mem_addr  = core_addr;
            mem_wdata = diff;
        end else begin
            mem_we    = load_we;
            mem_addr  = load_addr;
            mem_wdata = load_data;
        end
    end

    subbr_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk       (clk),
        .we        (mem_we),
        .addr      (mem_addr),
        .wdata     (mem_wdata),
        .rdata     (mem_rdata),
        .peek_addr (peek_addr),
        .peek_data (peek_data)
    );

    assign pc   = cur_pc;
    assign halt = (state == S_HALT);
endmodule

// File: rtl/subbr_chk.sv
module subbr_chk #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              halt,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] target
);
    // R7
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt);

    // R7
    halt_pc_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        halt |=> ($stable(pc) && !busy));

    // R2
    start_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !halt) |=> busy);

    // R4 R5
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(pc) || (pc == $past(pc) + ADDR_W'(4)) || (pc == $past(target))));
endmodule

bind subbr_core subbr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .halt   (halt),
    .pc     (pc),
    .target (jump_tgt)
);

// File: tb/sim_subbr_core.sv
`timescale 1ns/1ps
module sim_subbr_core;
    localparam int DW = 16;
    localparam int AW = 8;
    localparam int ONE  = 'h90;
    localparam int ZERO = 'h91;
    localparam int SCR  = 'h92;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          load_we = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [DW-1:0] load_data = '0;
    logic [AW-1:0] peek_addr = '0;
    logic [DW-1:0] peek_data;
    logic [AW-1:0] pc;
    logic          busy;
    logic          halt;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    subbr_core #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .start(start),
        .load_we(load_we), .load_addr(load_addr), .load_data(load_data),
        .peek_addr(peek_addr), .peek_data(peek_data),
        .pc(pc), .busy(busy), .halt(halt)
    );

    task automatic check(input string req, input string what, input int unsigned actual,
                         input int unsigned expected);
        n_checks++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, actual, expected);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; start = 1'b0; load_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic poke(input int a, input int unsigned v);
        load_we = 1'b1; load_addr = AW'(a); load_data = DW'(v);
        @(negedge clk);
        load_we = 1'b0;
    endtask

    task automatic peek(input int a, output int unsigned v);
        peek_addr = AW'(a);
        #1;
        v = peek_data;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < (1 << AW); i++) poke(i, 0);
        poke(ONE, 1);
    endtask

    task automatic put_instr(input int p, input int a, input int b, input int c, input int d);
        poke(p, a); poke(p + 1, b); poke(p + 2, c); poke(p + 3, d);
    endtask

    task automatic put_halt(input int p);
        put_instr(p, ONE, ZERO, SCR, p);
    endtask

    // Returns clock edges counted from the edge that sampled start until halt is seen
    task automatic run(output int edges, output logic launched);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        launched = busy;
        edges = 1;
        while (!halt && edges < 3000) begin
            @(negedge clk);
            edges++;
        end
    endtask

    task automatic t_reset_idle();
        int unsigned v;
        do_reset();
        check("R1", "pc after reset", pc, 0);
        check("R1", "busy after reset", busy, 0);
        check("R1", "halt after reset", halt, 0);
        repeat (10) @(negedge clk);
        check("R2", "busy without start", busy, 0);
        check("R2", "pc without start", pc, 0);
        v = 0;
    endtask

    task automatic t_fall_through();
        int edges; logic launched; int unsigned v;
        do_reset(); clear_mem();
        poke('h80, 5); poke('h81, 12);
        put_instr(0, 'h80, 'h81, 'h82, 'h10);
        put_halt(4);
        run(edges, launched);
        check("R2", "busy after start", launched, 1);
        check("R8", "cycles for 2 instructions", edges, 15);
        check("R5", "pc at halt", pc, 4);
        peek('h82, v);
        check("R3", "12-5 stored", v, 7);
        check("R7", "halt raised", halt, 1);
    endtask

    task automatic t_taken();
        int edges; logic launched; int unsigned v;
        do_reset(); clear_mem();
        poke('h80, 9); poke('h81, 3);
        put_instr(0, 'h80, 'h81, 'h82, 'h20);
        put_halt(4);
        put_halt('h20);
        run(edges, launched);
        check("R4", "pc after negative", pc, 'h20);
        peek('h82, v);
        check("R3", "3-9 stored", v, 'hFFFA);
        check("R8", "cycles taken path", edges, 15);
    endtask

    task automatic t_zero();
        int edges; logic launched; int unsigned v;
        do_reset(); clear_mem();
        poke('h80, 7); poke('h81, 7); poke('h82, 'h1111);
        put_instr(0, 'h80, 'h81, 'h82, 'h30);
        put_halt(4);
        put_halt('h30);
        run(edges, launched);
        check("R5", "zero falls through", pc, 4);
        peek('h82, v);
        check("R3", "7-7 stored", v, 0);
        check("R8", "cycles zero case", edges, 15);
    endtask

    task automatic t_alias();
        int edges; logic launched; int unsigned v;
        do_reset(); clear_mem();
        poke('h80, 10); poke('h81, 4); poke('h83, 3); poke('h84, 20);
        put_instr(0, 'h80, 'h81, 'h80, 8);
        put_halt(4);
        put_instr(8, 'h83, 'h84, 'h84, 'h40);
        put_halt('hC);
        put_halt('h40);
        run(edges, launched);
        check("R6", "pc after aliased pair", pc, 'hC);
        peek('h80, v);
        check("R6", "C equals A result", v, 'hFFFA);
        peek('h84, v);
        check("R6", "C equals B result", v, 17);
        check("R8", "cycles for 3 instructions", edges, 22);
    endtask

    task automatic t_overflow();
        int edges; logic launched; int unsigned v;
        do_reset(); clear_mem();
        poke('h80, 1); poke('h81, 'h8000); poke('h83, 'hFFFF); poke('h84, 'h7FFF);
        put_instr(0, 'h80, 'h81, 'h82, 'h20);
        put_instr(4, 'h83, 'h84, 'h85, 'h10);
        put_halt(8);
        put_halt('h10);
        put_halt('h20);
        run(edges, launched);
        peek('h82, v);
        check("R10", "0x8000-1 wraps", v, 'h7FFF);
        peek('h85, v);
        check("R10", "0x7FFF-(-1) wraps", v, 'h8000);
        check("R10", "pc after sign-bit decisions", pc, 'h10);
        check("R8", "cycles overflow program", edges, 22);
    endtask

    task automatic t_loop_and_lock();
        int edges; int unsigned v;
        do_reset(); clear_mem();
        poke('h80, 3);
        put_instr(0, ONE, 'h80, 'h80, 8);
        put_instr(4, ONE, ZERO, SCR, 0);
        put_halt(8);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        edges = 1;
        while (!halt && edges < 3000) begin
            if (edges == 10) begin
                load_we = 1'b1; load_addr = AW'('hA0); load_data = DW'('h5555);
            end else begin
                load_we = 1'b0;
            end
            @(negedge clk);
            edges++;
        end
        load_we = 1'b0;
        check("R8", "cycles for 8 instructions", edges, 57);
        peek('h80, v);
        check("R3", "loop counter final", v, 'hFFFF);
        peek('hA0, v);
        check("R9", "loader write while busy ignored", v, 0);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        check("R7", "halt held after start", halt, 1);
        check("R7", "busy stays low when halted", busy, 0);
        check("R7", "pc held when halted", pc, 8);
        poke('hA1, 'h2222);
        peek('hA1, v);
        check("R9", "loader write when not busy", v, 'h2222);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset_idle();
        t_fall_through();
        t_taken();
        t_zero();
        t_alias();
        t_overflow();
        t_loop_and_lock();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule